// File: doc/BRIEF.md
# Reconfigurable Second-Order Delta-Sigma Modulator

This block converts a stream of 16-bit signed samples into short quantized codes for a multi-level DAC. It uses error feedback. Each sample is added to a shaped combination of the two most recent quantization errors. The sum is truncated to a coarse code, and the discarded low-order bits become the next error. A two-bit mode input selects the noise shaping at run time: low-pass, band-pass centred at a quarter of the sample rate, or high-pass. Every feedback coefficient is 0, ±1 or ±2, so the datapath needs only shifts, adds and negation.

The recursion is unrolled across `LANES` parallel lanes, four by default. One clock therefore carries a block of consecutive samples. Lane 0 holds the earliest sample of the block. The lanes inside a block are chained through combinational logic. The last two lane errors are registered so that the next block can continue the recursion. When the mode changes, the stored errors are dropped and the new block starts from zero error.

Top module: `dsm_ti_mod`

## Requirements
- R1: Each clock the block accepts `LANES` samples (lane k in `samp_i[k*16 +: 16]`, lane 0 earliest). After one clock edge it presents one 8-bit signed code per lane in `code_o[k*8 +: 8]`. The code is floor(v / 2048), where v is the lane's 19-bit signed loop sum.
- R2: For a sample x, v = x + a1*e[n-1] + a2*e[n-2]. The new error e[n] is the unsigned value of the low 11 bits of v, in the range 0..2047.
- R3: Mode code 0 (low-pass) uses a1 = +2, a2 = -1.
- R4: Mode code 1 (band-pass at a quarter of the sample rate) uses a1 = 0, a2 = -1.
- R5: Mode code 2 (high-pass) uses a1 = -2, a2 = -1.
- R6: Mode code 3 uses the low-pass coefficients. It is still a distinct mode code for the purpose of R8.
- R7: The recursion runs across block boundaries. Lane 0 uses the errors of the previous block's last and second-to-last lanes. Lane 1 uses lane 0's error and the previous block's last-lane error.
- R8: When `mode_i` differs from the mode used in the previous clock, both prior errors for the new block are taken as zero, and the new mode applies to that block.
- R9: Synchronous active-high reset drives every code to zero, clears both stored errors and sets the stored mode to code 0.
- R10: Every input from -32768 to +32767, in every mode, gives codes within -19..+17 with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample-block clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Noise-shaping select (0 LP, 1 BP, 2 HP, 3 LP) |
| samp_i | input | LANES*16 | Block of signed samples, lane 0 in the low bits |
| code_o | output | LANES*8 | Registered signed output codes, lane 0 in the low bits |

## Verification
A corrupted stored error shows up in the codes of the very next block. The corruption then keeps spreading through every later block, because the recursion never forgets unless the mode changes. A wrong coefficient or a broken lane chain therefore makes codes diverge from a bit-exact model within one or two blocks. A missed clear on a mode change shows on lane 0 of the first block in the new mode. That code must then equal the sample alone, truncated.

// File: rtl/dsm_ti_pkg.sv
`timescale 1ns/1ps
package dsm_ti_pkg;

  typedef enum logic [1:0] {
    MODE_LP  = 2'd0,
    MODE_BP  = 2'd1,
    MODE_HP  = 2'd2,
    MODE_LP2 = 2'd3
  } nsh_mode_e;

  // first-tap control: a1 is 0 or +/-2, a2 is always -1
  typedef struct packed {
    logic tap1_on;
    logic tap1_neg;
  } efb_coef_t;

  function automatic efb_coef_t coef_of(nsh_mode_e m);
    efb_coef_t c;
    case (m)
      MODE_BP: begin c.tap1_on = 1'b0; c.tap1_neg = 1'b0; end
      MODE_HP: begin c.tap1_on = 1'b1; c.tap1_neg = 1'b1; end
      default: begin c.tap1_on = 1'b1; c.tap1_neg = 1'b0; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dsm_fb_shift.sv
`timescale 1ns/1ps
module dsm_fb_shift
  import dsm_ti_pkg::*;
#(
  parameter int EW = 11,
  parameter int AW = 19
) (
  input  logic [1:0]           mode_i,
  input  logic [EW-1:0]        e1_i,
  input  logic [EW-1:0]        e2_i,
  output logic signed [AW-1:0] fb_o
);
  function automatic logic signed [AW-1:0] widen(input logic [EW-1:0] e);
    return $signed({{(AW-EW){1'b0}}, e});
  endfunction

  efb_coef_t              coef;
  logic signed [AW-1:0]   e1x, e2x, dbl1, tap1;

  always_comb begin
    coef = coef_of(nsh_mode_e'(mode_i));
    e1x  = widen(e1_i);
    e2x  = widen(e2_i);
    dbl1 = e1x <<< 1;
    if (!coef.tap1_on)      tap1 = '0;
    else if (coef.tap1_neg) tap1 = -dbl1;
    else                    tap1 = dbl1;
    fb_o = tap1 - e2x;
  end
endmodule

// File: rtl/dsm_quant.sv
`timescale 1ns/1ps
module dsm_quant #(
  parameter int AW  = 19,
  parameter int LSB = 11
) (
  input  logic signed [AW-1:0]     sum_i,
  output logic signed [AW-LSB-1:0] code_o,
  output logic [LSB-1:0]           err_o
);
  // floor truncation: code*2^LSB + err == sum, err unsigned
  always_comb begin
    code_o = sum_i[AW-1:LSB];
    err_o  = sum_i[LSB-1:0];
  end
endmodule

// File: rtl/dsm_lane.sv
`timescale 1ns/1ps
module dsm_lane #(
  parameter int DW  = 16,
  parameter int AW  = 19,
  parameter int LSB = 11
) (
  input  logic [1:0]               mode_i,
  input  logic [DW-1:0]            x_i,
  input  logic [LSB-1:0]           e1_i,
  input  logic [LSB-1:0]           e2_i,
  output logic signed [AW-1:0]     fb_o,
  output logic signed [AW-LSB-1:0] code_o,
  output logic [LSB-1:0]           err_o
);
  logic signed [AW-1:0] x_ext, sum;

  dsm_fb_shift #(.EW(LSB), .AW(AW)) u_fb (
    .mode_i (mode_i),
    .e1_i   (e1_i),
    .e2_i   (e2_i),
    .fb_o   (fb_o)
  );

  always_comb begin
    x_ext = $signed({{(AW-DW){x_i[DW-1]}}, x_i});
    sum   = x_ext + fb_o;
  end

  dsm_quant #(.AW(AW), .LSB(LSB)) u_q (
    .sum_i  (sum),
    .code_o (code_o),
    .err_o  (err_o)
  );
endmodule

// File: rtl/dsm_ti_mod.sv
`timescale 1ns/1ps
module dsm_ti_mod
  import dsm_ti_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int QW    = 5,
  parameter int GUARD = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic [1:0]                  mode_i,
  input  logic [LANES*DW-1:0]         samp_i,
  output logic [LANES*(QW+GUARD)-1:0] code_o
);
  localparam int LSB = DW - QW;
  localparam int AW  = DW + GUARD;
  localparam int OW  = AW - LSB;
  localparam int EMAX_I  = (2**LSB) - 1;
  localparam int CMAX_I  = ((2**(DW-1)) - 1 + 2*EMAX_I) / (2**LSB);
  localparam int CMIN_I  = -((2**(DW-1)) + 3*EMAX_I + (2**LSB) - 1) / (2**LSB);
  localparam logic signed [OW-1:0] CODE_MAX = OW'(CMAX_I);
  localparam logic signed [OW-1:0] CODE_MIN = OW'(CMIN_I);
  localparam logic signed [AW-1:0] FB_M1 = AW'(EMAX_I);
  localparam logic signed [AW-1:0] FB_M2 = AW'(2*EMAX_I);
  localparam logic signed [AW-1:0] FB_M3 = AW'(3*EMAX_I);

  logic [1:0]           mode_q;
  logic [LSB-1:0]       hist1_q, hist2_q;
  logic [LANES*OW-1:0]  code_q;
  logic                 mode_chg;
  logic [LSB-1:0]       prev1, prev2;

  logic [LSB-1:0]       e1_w   [LANES];
  logic [LSB-1:0]       e2_w   [LANES];
  logic [LSB-1:0]       err_w  [LANES];
  logic signed [AW-1:0] fb_w   [LANES];
  logic signed [OW-1:0] code_w [LANES];

  // mode change: prior errors of the new block are zero (R8)
  always_comb begin
    mode_chg = (mode_i != mode_q);
    prev1    = mode_chg ? '0 : hist1_q;
    prev2    = mode_chg ? '0 : hist2_q;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_first
      assign e1_w[k] = prev1;
      assign e2_w[k] = prev2;
    end else if (k == 1) begin : g_second
      assign e1_w[k] = err_w[0];
      assign e2_w[k] = prev1;
    end else begin : g_rest
      assign e1_w[k] = err_w[k-1];
      assign e2_w[k] = err_w[k-2];
    end

    dsm_lane #(.DW(DW), .AW(AW), .LSB(LSB)) u_lane (
      .mode_i (mode_i),
      .x_i    (samp_i[k*DW +: DW]),
      .e1_i   (e1_w[k]),
      .e2_i   (e2_w[k]),
      .fb_o   (fb_w[k]),
      .code_o (code_w[k]),
      .err_o  (err_w[k])
    );

    // R3 / R6: low-pass coefficients bound the feedback to [-M, 2M]
    a_r3_lp_fb_range: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == 2'd0 || mode_i == 2'd3) |-> (fb_w[k] >= -FB_M1 && fb_w[k] <= FB_M2));
    // R4: band-pass feedback is -e[n-2] only
    a_r4_bp_fb_range: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == 2'd1) |-> (fb_w[k] >= -FB_M1 && fb_w[k] <= 0));
    // R5: high-pass feedback lies in [-3M, 0]
    a_r5_hp_fb_range: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == 2'd2) |-> (fb_w[k] >= -FB_M3 && fb_w[k] <= 0));
    // R10: registered codes never wrap
    a_r10_code_range: assert property (@(posedge clk_i) disable iff (rst_i)
      ($signed(code_q[k*OW +: OW]) >= CODE_MIN && $signed(code_q[k*OW +: OW]) <= CODE_MAX));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q  <= 2'd0;
      hist1_q <= '0;
      hist2_q <= '0;
      code_q  <= '0;
    end else begin
      mode_q  <= mode_i;
      hist1_q <= err_w[LANES-1];
      hist2_q <= err_w[LANES-2];
      for (int k = 0; k < LANES; k++) code_q[k*OW +: OW] <= code_w[k];
    end
  end

  assign code_o = code_q;

  // lane 0 sample alone, truncated: the expected first code after a mode change
  logic signed [AW-1:0] x0_ext;
  logic signed [OW-1:0] x0_code;
  always_comb begin
    x0_ext  = $signed({{(AW-DW){samp_i[DW-1]}}, samp_i[DW-1:0]});
    x0_code = x0_ext[AW-1:LSB];
  end

  a_r8_mode_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_chg |=> ($signed(code_q[OW-1:0]) == $past(x0_code)));

  a_r7_block_carry: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mode_chg && !$past(rst_i)) |->
      (e1_w[0] == $past(err_w[LANES-1]) && e2_w[0] == $past(err_w[LANES-2])));
endmodule

// File: tb/dsm_ti_mod_bench.sv
`timescale 1ns/1ps
module dsm_ti_mod_bench;
  localparam int L = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'd0;
  logic [L*16-1:0] samp = '0;
  logic [L*8-1:0]  code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int m_e1, m_e2;
  logic [1:0] m_mode;

  always #2.5 clk = ~clk;

  dsm_ti_mod u_dsm_ti_mod (
    .clk_i  (clk),
    .rst_i  (rst),
    .mode_i (mode),
    .samp_i (samp),
    .code_o (code)
  );

  task automatic check(input int got, input int exp, input string req);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  function automatic int lane_code(input int k);
    return int'($signed(code[k*8 +: 8]));
  endfunction

  task automatic model_reset();
    m_e1 = 0; m_e2 = 0; m_mode = 2'd0;
  endtask

  // drive one block, advance the reference recursion, compare after the edge
  task automatic run_block(input int xs[L], input logic [1:0] md, input string req);
    int exp[L];
    int a1, a2, v;
    @(negedge clk);
    for (int k = 0; k < L; k++) samp[k*16 +: 16] = 16'(xs[k]);
    mode = md;
    if (md != m_mode) begin m_e1 = 0; m_e2 = 0; end
    m_mode = md;
    a2 = -1;
    a1 = (md == 2'd1) ? 0 : (md == 2'd2) ? -2 : 2;
    for (int k = 0; k < L; k++) begin
      v = xs[k] + a1 * m_e1 + a2 * m_e2;
      exp[k] = v >>> 11;
      m_e2 = m_e1;
      m_e1 = v & 2047;
    end
    @(posedge clk); #1;
    for (int k = 0; k < L; k++) begin
      check(lane_code(k), exp[k], req);
      if (lane_code(k) < -19 || lane_code(k) > 17) check(lane_code(k), 0, "R10 range");
    end
  endtask

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  task automatic t_reset();
    int xs[L];
    rst = 1'b1;
    samp = {L{16'h7abc}};
    mode = 2'd2;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < L; k++) check(lane_code(k), 0, "R9 reset code");
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    // mode still 2 at release: R8 clears, then zero input in LP gives zeros
    for (int k = 0; k < L; k++) xs[k] = 0;
    run_block(xs, 2'd0, "R9 zero after reset");
    for (int k = 0; k < L; k++) check(lane_code(k), 0, "R9 zero codes");
  endtask

  task automatic t_mode_run(input logic [1:0] md, input string req, input int nblk);
    int xs[L];
    for (int b = 0; b < nblk; b++) begin
      for (int k = 0; k < L; k++) begin
        if (b < nblk / 2) xs[k] = ((b * L + k) * 523) % 30000 - 15000;
        else              xs[k] = rnd16();
      end
      run_block(xs, md, req);
    end
  endtask

  task automatic t_full_scale();
    int xs[L];
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 12; b++) begin
        for (int k = 0; k < L; k++) xs[k] = 32767;
        run_block(xs, 2'(m), "R10 full scale pos");
      end
      for (int b = 0; b < 12; b++) begin
        for (int k = 0; k < L; k++) xs[k] = -32768;
        run_block(xs, 2'(m), "R10 full scale neg");
      end
      for (int b = 0; b < 6; b++) begin
        for (int k = 0; k < L; k++) xs[k] = (k % 2 == 0) ? 32767 : -32768;
        run_block(xs, 2'(m), "R10 alternating full scale");
      end
    end
  endtask

  task automatic t_switching();
    int xs[L];
    for (int b = 0; b < 40; b++) begin
      for (int k = 0; k < L; k++) xs[k] = rnd16();
      // lane 0 after a change must be the sample alone, truncated (R8)
      run_block(xs, 2'((b / 3) % 4), "R8 mode switch");
      if (b % 3 == 0 && b > 0) check(lane_code(0), xs[0] >>> 11, "R8 cleared lane0");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    t_reset();
    t_mode_run(2'd0, "R3 R1 R2 R7 low-pass", 40);
    t_mode_run(2'd1, "R4 band-pass", 40);
    t_mode_run(2'd2, "R5 high-pass", 40);
    t_mode_run(2'd3, "R6 code 3 as low-pass", 30);
    t_full_scale();
    t_switching();
    t_reset();
    t_mode_run(2'd1, "R7 carry after reset", 10);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule